// File: doc/BRIEF.md
# Half-Duplex Tag Frame Capture and Verifier

This block sits behind the analog front end of a low-frequency half-duplex identification reader. It receives three asynchronous levels: a phase signal that separates the charge phase from the read phase, the demodulated serial data, and a bit-sampling strobe that the front end derives from the carrier. During the read phase, each new strobe pulse shifts one data bit into a capture register. When a full frame has been collected, the register is compared with a reference value that is fixed when the block is built. The block then raises either a match flag or a mismatch flag.

Each time a charge phase begins, any partial frame and the previous verdict are cleared. This keeps a stale read from being reported in a later cycle. Framing bytes and CRC are not checked. The captured frame is brought out for observation.

Top module: `tag_frame_checker`

## Requirements
- R1: After synchronous reset, `frame_o` is all zeros and both `match_o` and `mismatch_o` are low.
- R2: While the read phase is active (`rd_phase_i` = 1), each rising edge of `strobe_i` shifts the current `data_i` value into bit 0 of `frame_o`. Older bits move toward the MSB, so after a full frame the first received bit sits in bit FRAME_BITS-1.
- R3: While the charge phase is active (`rd_phase_i` = 0), `strobe_i` and `data_i` have no effect on `frame_o`, `match_o` or `mismatch_o`.
- R4: A strobe held high for any number of cycles samples exactly one bit.
- R5: When the FRAME_BITS-th bit is captured, `match_o` rises if `frame_o` equals REF_FRAME, and `mismatch_o` rises otherwise.
- R6: `match_o` and `mismatch_o` are never high together. Once raised, a flag stays high until the next charge-phase onset.
- R7: A charge-phase onset (falling edge of the synchronized `rd_phase_i`) clears `frame_o`, the bit count and both flags.
- R8: A read phase that ends with fewer than FRAME_BITS bits raises neither flag.
- R9: Strobes that arrive after a complete frame, within the same read phase, change neither `frame_o` nor the flags.
- R10: Each input passes through a two-flop synchronizer. A strobe rise that is applied between clock edges updates `frame_o` on the third following rising clock edge, and not before. The verdict flag for the last bit follows one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_phase_i | input | 1 | Asynchronous phase level: 1 = read phase, 0 = charge phase |
| data_i | input | 1 | Asynchronous demodulated serial data |
| strobe_i | input | 1 | Asynchronous bit-sampling strobe |
| frame_o | output | FRAME_BITS | Captured frame, MSB received first |
| match_o | output | 1 | Complete frame equals the reference |
| mismatch_o | output | 1 | Complete frame differs from the reference |

## Verification
The bench builds the block with FRAME_BITS = 8 and REF_FRAME = 8'hA5. This small size lets it sweep all 256 possible frames through a full charge/read cycle. Every frame value is checked for the correct capture order and the correct verdict, and exactly one of those frames is the match case. The short frame also makes it cheap to cover partial reads, strobes after a complete frame, and long strobes. An exact cycle-latency probe runs through the synchronizers.

// File: rtl/tfc_pkg.sv
package tfc_pkg;
  typedef struct packed {
    logic phase;
    logic data;
    logic strobe;
  } tfc_in_t;

  localparam int TFC_IN_W = $bits(tfc_in_t);
endpackage

// File: rtl/tfc_sync.sv
module tfc_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/tfc_capture.sv
module tfc_capture #(
  parameter int FRAME_BITS = 128
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  phase,
  input  logic                  data,
  input  logic                  strobe,
  output logic [FRAME_BITS-1:0] frame,
  output logic                  full,
  output logic                  onset
);
  localparam int CW = $clog2(FRAME_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(FRAME_BITS);

  logic          phase_q, strobe_q;
  logic [CW-1:0] cnt;
  logic          rise, take;

  assign onset = phase_q & ~phase;
  assign rise  = strobe & ~strobe_q;
  assign take  = phase & rise & (cnt != LAST);
  assign full  = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      phase_q  <= phase;
      strobe_q <= strobe;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || onset) begin
      frame <= '0;
      cnt   <= '0;
    end else if (take) begin
      frame <= {frame[FRAME_BITS-2:0], data};
      cnt   <= cnt + 1'b1;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R9
  AST_CHARGE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!phase && !phase_q) |=> ($stable(frame) && $stable(cnt))); // R3
  AST_FULL_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (full && !onset) |=> $stable(frame)); // R9
endmodule

// File: rtl/tfc_verdict.sv
module tfc_verdict #(
  parameter int                  FRAME_BITS = 128,
  parameter logic [FRAME_BITS-1:0] REF_FRAME = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  onset,
  input  logic                  full,
  input  logic [FRAME_BITS-1:0] frame,
  output logic                  match_o,
  output logic                  mismatch_o
);
  logic decided;
  assign decided = match_o | mismatch_o;

  always_ff @(posedge clk) begin
    if (rst || onset) begin
      match_o    <= 1'b0;
      mismatch_o <= 1'b0;
    end else if (full && !decided) begin
      match_o    <= (frame == REF_FRAME);
      mismatch_o <= (frame != REF_FRAME);
    end
  end

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(match_o && mismatch_o)); // R6
  AST_ONSET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    onset |=> (!match_o && !mismatch_o)); // R7
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (decided && !onset) |=> ($stable(match_o) && $stable(mismatch_o))); // R6
  AST_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
    decided |-> full); // R8
endmodule

// File: rtl/tag_frame_checker.sv
module tag_frame_checker #(
  parameter int                    FRAME_BITS  = 128,
  parameter int                    SYNC_STAGES = 2,
  parameter logic [FRAME_BITS-1:0] REF_FRAME   = {FRAME_BITS/8{8'h5A}}
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_phase_i,
  input  logic                  data_i,
  input  logic                  strobe_i,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic                  match_o,
  output logic                  mismatch_o
);
  import tfc_pkg::*;

  tfc_in_t raw_in, sync_in;
  logic    full, onset;

  assign raw_in = '{phase: rd_phase_i, data: data_i, strobe: strobe_i};

  tfc_sync #(.W(TFC_IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (sync_in)
  );

  tfc_capture #(.FRAME_BITS(FRAME_BITS)) u_capture (
    .clk    (clk),
    .rst    (rst),
    .phase  (sync_in.phase),
    .data   (sync_in.data),
    .strobe (sync_in.strobe),
    .frame  (frame_o),
    .full   (full),
    .onset  (onset)
  );

  tfc_verdict #(.FRAME_BITS(FRAME_BITS), .REF_FRAME(REF_FRAME)) u_verdict (
    .clk        (clk),
    .rst        (rst),
    .onset      (onset),
    .full       (full),
    .frame      (frame_o),
    .match_o    (match_o),
    .mismatch_o (mismatch_o)
  );
endmodule

// File: tb/tag_frame_checker_bench.sv
module tag_frame_checker_bench;
  localparam int N = 8;
  localparam logic [N-1:0] REFV = 8'hA5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_phase_i = 1'b0, data_i = 1'b0, strobe_i = 1'b0;
  logic [N-1:0] frame_o;
  logic match_o, mismatch_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tag_frame_checker #(.FRAME_BITS(N), .SYNC_STAGES(2), .REF_FRAME(REFV)) u_tag_frame_checker (
    .clk(clk), .rst(rst), .rd_phase_i(rd_phase_i), .data_i(data_i),
    .strobe_i(strobe_i), .frame_o(frame_o), .match_o(match_o), .mismatch_o(mismatch_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    data_i = b;  cyc(3);
    strobe_i = 1'b1; cyc(4);
    strobe_i = 1'b0; cyc(4);
  endtask

  task automatic go_charge();
    rd_phase_i = 1'b0; cyc(6);
  endtask

  task automatic go_read();
    rd_phase_i = 1'b1; cyc(6);
  endtask

  task automatic chk_flags(input string req, input logic em, input logic ex);
    chk(match_o == em, req, 32'(match_o), 32'(em));
    chk(mismatch_o == ex, req, 32'(mismatch_o), 32'(ex));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(4);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    chk(frame_o == '0, "R1 frame", 32'(frame_o), 0);
    chk_flags("R1 flags", 1'b0, 1'b0);

    // R3: strobes during charge ignored
    data_i = 1'b1;
    for (int k = 0; k < 5; k++) begin
      strobe_i = 1'b1; cyc(4); strobe_i = 1'b0; cyc(4);
    end
    chk(frame_o == '0, "R3 frame in charge", 32'(frame_o), 0);
    chk_flags("R3 flags in charge", 1'b0, 1'b0);

    // R10 latency probe and R5 last-bit verdict latency
    go_read();
    data_i = 1'b1; cyc(3);
    strobe_i = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(frame_o == '0, "R10 no early capture", 32'(frame_o), 0);
    @(negedge clk);
    chk(frame_o == 8'h01, "R10 capture on third edge", 32'(frame_o), 1);
    cyc(3); strobe_i = 1'b0; cyc(4);
    for (int i = N-2; i >= 1; i--) send_bit(REFV[i]);
    data_i = REFV[0]; cyc(3);
    strobe_i = 1'b1;
    @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
    chk(frame_o == REFV, "R2 frame after last bit", 32'(frame_o), 32'(REFV));
    chk_flags("R10 verdict not yet", 1'b0, 1'b0);
    @(negedge clk);
    chk_flags("R5 match one edge later", 1'b1, 1'b0);
    strobe_i = 1'b0;
    cyc(50);
    chk_flags("R6 match held", 1'b1, 1'b0);
    go_charge();
    chk_flags("R7 onset clears flags", 1'b0, 1'b0);
    chk(frame_o == '0, "R7 onset clears frame", 32'(frame_o), 0);

    // R4: long strobe samples once
    go_read();
    data_i = 1'b1; cyc(3);
    strobe_i = 1'b1; cyc(40); strobe_i = 1'b0; cyc(4);
    chk(frame_o == 8'h01, "R4 one bit per long strobe", 32'(frame_o), 1);
    for (int i = 1; i < N; i++) send_bit(1'b1);
    chk(frame_o == 8'hFF, "R4 frame FF", 32'(frame_o), 32'hFF);
    chk_flags("R5 mismatch FF", 1'b0, 1'b1);
    go_charge();

    // R8: partial frame
    go_read();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    cyc(10);
    chk(frame_o == 8'h16, "R2 partial order", 32'(frame_o), 32'h16);
    chk_flags("R8 partial no verdict", 1'b0, 1'b0);
    go_charge();
    chk(frame_o == '0, "R7 partial discarded", 32'(frame_o), 0);
    chk_flags("R8 after charge", 1'b0, 1'b0);

    // Exhaustive sweep of all frames
    for (int v = 0; v < (1 << N); v++) begin
      logic [N-1:0] val;
      logic em;
      val = N'(v);
      em = (val == REFV);
      go_read();
      chk(frame_o == '0, "R7 clean start", 32'(frame_o), 0);
      for (int i = N-1; i >= 0; i--) send_bit(val[i]);
      chk(frame_o == val, "R2 sweep frame", 32'(frame_o), 32'(val));
      chk_flags("R5 sweep verdict", em, ~em);
      chk(!(match_o && mismatch_o), "R6 exclusive", {match_o, mismatch_o}, 0);
      send_bit(~val[0]);
      send_bit(val[0]);
      chk(frame_o == val, "R9 extra strobes ignored", 32'(frame_o), 32'(val));
      chk_flags("R9 verdict unchanged", em, ~em);
      go_charge();
      chk_flags("R7 sweep clear", 1'b0, 1'b0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule